// File: doc/BRIEF.md
# Host-Facing Serial Port Register Bridge

This block is a two-sided register file. A host bus sees a small byte-wide register map laid out like a 16550 UART. A local microprocessor sits on a second bus and plays the part of the UART in firmware. The local processor writes the four modem line states. The block then derives the matching change flags, and the host reads and clears them. The host programs a baud divisor through two latch bytes, which it can reach only while the divisor access bit of the line control register is set. Each host write to a divisor byte raises a sticky interrupt, so the local processor can fetch the new divisor and reconfigure its own serial engine. The host also has a scratch byte, which the local processor can see but which never interrupts it.

Both buses use single-cycle strobes. Read data is combinational from the current register state. Register updates and strobe side effects take hold at the rising clock edge on which the strobe is sampled.

Top module: `uart_mimic_bridge`

## Requirements
- R1: After reset, all of the following read 0x00: host offsets 0, 1, 3, 6 and 7, and local offsets F7h, F8h and F9h. The local interrupt `lirq` is 0.
- R2: The local processor sets modem status bits 7..4 by writing local offset F6h, with data bits 7..4 as the new values. A host write to offset 6 has no effect on the modem status register.
- R3: A local write that changes bit 7 (carrier) sets bit 3. A change of bit 5 (data set ready) sets bit 1. A change of bit 4 (clear to send) sets bit 0. Writing unchanged values sets no change bit.
- R4: Bit 2 is set only when bit 6 (ring) goes from 1 to 0. A 0-to-1 ring change leaves bit 2 at 0.
- R5: A host read of offset 6 returns the full register, then clears bits 3..0 from the next cycle on. Bits 7..4 are unchanged by the read.
- R6: If a host read of offset 6 and a status transition fall in the same cycle, the change bit of that transition is 1 after the read.
- R7: The scratch byte at host offset 7 can be written and read back by the host, and the local processor reads it at F7h. A host write to it leaves `lirq` unchanged.
- R8: The divisor access bit is bit 7 of the line control byte at host offset 3, which the host can read and write. While this bit is 1, host offsets 0 and 1 reach the divisor low and high bytes, and the local processor reads them at F8h and F9h. While it is 0, host writes to offsets 0 and 1 change neither byte and raise no interrupt, and host reads there return 0x00.
- R9: A host write to either divisor byte sets `lirq` from the next cycle. `lirq` stays 1 until a local read of F8h or F9h. Host reads do not clear it.
- R10: If a local divisor read and a host divisor write fall in the same cycle, `lirq` stays 1.
- R11: Local reads of offsets that are not mapped return 0x00. Local writes to any offset other than F6h have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| haddr | input | 3 | Host register offset |
| hwdata | input | 8 | Host write data |
| hwr | input | 1 | Host write strobe |
| hrd | input | 1 | Host read strobe |
| hrdata | output | 8 | Host read data |
| laddr | input | LADDR_W | Local register offset |
| lwdata | input | 8 | Local write data |
| lwr | input | 1 | Local write strobe |
| lrd | input | 1 | Local read strobe |
| lrdata | output | 8 | Local read data |
| lirq | output | 1 | Sticky divisor-written interrupt to the local processor |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is a host read that clears the modem change bits and a local write that creates a new transition. The bench drives both strobes on one cycle, flipping clear-to-send while the host reads offset 6. It then expects that read to return the old value and the next read to show bit 0 still set. The second pair is the local read that acknowledges the interrupt and a host divisor write. The bench issues both together, then judges that the local read returned the old divisor byte and that `lirq` stays high.

// File: rtl/mimic_pkg.sv
package mimic_pkg;
   localparam int HA_W     = 3;
   localparam int BYTE_W   = 8;
   localparam logic [HA_W-1:0] H_DIV_LO = 3'd0;
   localparam logic [HA_W-1:0] H_DIV_HI = 3'd1;
   localparam logic [HA_W-1:0] H_LINE   = 3'd3;
   localparam logic [HA_W-1:0] H_MODEM  = 3'd6;
   localparam logic [HA_W-1:0] H_SCRAT  = 3'd7;
   localparam int N_LINES  = 4;
   localparam int RING_IDX = 2;
endpackage

// File: rtl/mimic_modem_stat.sv
module mimic_modem_stat
   import mimic_pkg::*;
#(
   parameter int LINES = N_LINES,
   parameter int FALL_ONLY_IDX = RING_IDX
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_we,
   input  logic [LINES-1:0] set_val,
   input  logic             host_rd,
   output logic [2*LINES-1:0] stat
);
   logic [LINES-1:0] line_q;
   logic [LINES-1:0] delta_q;
   logic [LINES-1:0] evt;

   for (genvar i = 0; i < LINES; i++) begin : g_line
      if (i == FALL_ONLY_IDX) begin : g_fall
         assign evt[i] = set_we & line_q[i] & ~set_val[i];
      end else begin : g_any
         assign evt[i] = set_we & (line_q[i] ^ set_val[i]);
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       delta_q[i] <= 1'b0;
         else if (evt[i])  delta_q[i] <= 1'b1;
         else if (host_rd) delta_q[i] <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      line_q <= '0;
      else if (set_we) line_q <= set_val;
   end

   assign stat = {line_q, delta_q};

   // R5: a read with no concurrent write leaves every change bit clear
   a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !set_we) |=> (stat[LINES-1:0] == '0));
   // R6: a transition on the read cycle keeps its change bit
   a_r6_evt_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && set_we && (set_val[0] != stat[LINES])) |=> stat[0]);
   // R4: rising ring edge from a clear flag leaves it clear
   a_r4_ring_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (set_we && !stat[LINES+FALL_ONLY_IDX] && set_val[FALL_ONLY_IDX]
       && !stat[FALL_ONLY_IDX]) |=> !stat[FALL_ONLY_IDX]);
   // R3: carrier change sets its flag
   a_r3_dcd_delta: assert property (@(posedge clk) disable iff (!rst_n)
      (set_we && (set_val[LINES-1] != stat[2*LINES-1])) |=> stat[LINES-1]);
endmodule

// File: rtl/mimic_host_regs.sv
module mimic_host_regs
   import mimic_pkg::*;
#(
   parameter int DATA_W = BYTE_W,
   parameter int DLAB_POS = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [HA_W-1:0]   haddr,
   input  logic [DATA_W-1:0] hwdata,
   input  logic              hwr,
   output logic              dlab,
   output logic [DATA_W-1:0] line_q,
   output logic [DATA_W-1:0] scr_q,
   output logic [DATA_W-1:0] div_lo_q,
   output logic [DATA_W-1:0] div_hi_q,
   output logic              div_wr
);
   logic wr_lo, wr_hi;

   assign dlab   = line_q[DLAB_POS];
   assign wr_lo  = hwr && dlab && (haddr == H_DIV_LO);
   assign wr_hi  = hwr && dlab && (haddr == H_DIV_HI);
   assign div_wr = wr_lo | wr_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q   <= '0;
         scr_q    <= '0;
         div_lo_q <= '0;
         div_hi_q <= '0;
      end else begin
         if (hwr && haddr == H_LINE)  line_q   <= hwdata;
         if (hwr && haddr == H_SCRAT) scr_q    <= hwdata;
         if (wr_lo)                   div_lo_q <= hwdata;
         if (wr_hi)                   div_hi_q <= hwdata;
      end
   end

   // R8: with access bit clear, offset 0/1 writes leave the divisor intact
   a_r8_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (hwr && !dlab && haddr <= H_DIV_HI) |=> ($stable(div_lo_q) && $stable(div_hi_q)));
endmodule

// File: rtl/mimic_irq_flag.sv
module mimic_irq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic ack_i,
   output logic flag_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_o <= 1'b0;
      else if (set_i) flag_o <= 1'b1;
      else if (ack_i) flag_o <= 1'b0;
   end

   // R9: set raises the flag on the next cycle
   a_r9_set: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o);
   // R9: without an acknowledge the flag holds
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !ack_i) |=> flag_o);
   // R10: set and acknowledge together keep it high
   a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && ack_i) |=> flag_o);
endmodule

// File: rtl/uart_mimic_bridge.sv
module uart_mimic_bridge
   import mimic_pkg::*;
#(
   parameter int DATA_W   = BYTE_W,
   parameter int LADDR_W  = 8,
   parameter int DLAB_POS = 7,
   parameter logic [LADDR_W-1:0] L_MODEM  = 8'hF6,
   parameter logic [LADDR_W-1:0] L_SCRAT  = 8'hF7,
   parameter logic [LADDR_W-1:0] L_DIV_LO = 8'hF8,
   parameter logic [LADDR_W-1:0] L_DIV_HI = 8'hF9
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [HA_W-1:0]    haddr,
   input  logic [DATA_W-1:0]  hwdata,
   input  logic               hwr,
   input  logic               hrd,
   output logic [DATA_W-1:0]  hrdata,
   input  logic [LADDR_W-1:0] laddr,
   input  logic [DATA_W-1:0]  lwdata,
   input  logic               lwr,
   input  logic               lrd,
   output logic [DATA_W-1:0]  lrdata,
   output logic               lirq
);
   localparam int LINES = N_LINES;

   if (DATA_W != 2*LINES) begin : g_bad_width
      $error("DATA_W must be twice the modem line count");
   end
   if (DLAB_POS >= DATA_W) begin : g_bad_dlab
      $error("DLAB_POS outside the line control byte");
   end
   if (L_MODEM == L_SCRAT || L_DIV_LO == L_DIV_HI || L_SCRAT == L_DIV_LO) begin : g_bad_map
      $error("local offsets overlap");
   end

   logic              dlab, div_wr, modem_we, host_modem_rd, irq_ack;
   logic [DATA_W-1:0] line_q, scr_q, div_lo_q, div_hi_q, modem_q;
   wire  unused_lw_low = ^lwdata[LINES-1:0];

   assign modem_we      = lwr && (laddr == L_MODEM);
   assign host_modem_rd = hrd && (haddr == H_MODEM);
   assign irq_ack       = lrd && (laddr == L_DIV_LO || laddr == L_DIV_HI);

   mimic_host_regs #(.DATA_W(DATA_W), .DLAB_POS(DLAB_POS)) u_hregs (
      .clk, .rst_n, .haddr, .hwdata, .hwr,
      .dlab, .line_q, .scr_q, .div_lo_q, .div_hi_q, .div_wr
   );

   mimic_modem_stat #(.LINES(LINES)) u_modem (
      .clk, .rst_n,
      .set_we (modem_we),
      .set_val(lwdata[DATA_W-1:LINES]),
      .host_rd(host_modem_rd),
      .stat   (modem_q)
   );

   mimic_irq_flag u_irq (
      .clk, .rst_n, .set_i(div_wr), .ack_i(irq_ack), .flag_o(lirq)
   );

   always_comb begin
      unique case (haddr)
         H_DIV_LO: hrdata = dlab ? div_lo_q : '0;
         H_DIV_HI: hrdata = dlab ? div_hi_q : '0;
         H_LINE:   hrdata = line_q;
         H_MODEM:  hrdata = modem_q;
         H_SCRAT:  hrdata = scr_q;
         default:  hrdata = '0;
      endcase
   end

   always_comb begin
      if      (laddr == L_MODEM)  lrdata = modem_q;
      else if (laddr == L_SCRAT)  lrdata = scr_q;
      else if (laddr == L_DIV_LO) lrdata = div_lo_q;
      else if (laddr == L_DIV_HI) lrdata = div_hi_q;
      else                        lrdata = '0;
   end

   // R7: scratch writes never raise the interrupt
   a_r7_scr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!lirq && hwr && haddr == H_SCRAT) |=> !lirq);
   // R2: host write to the modem offset alone changes nothing there
   a_r2_host_ro: assert property (@(posedge clk) disable iff (!rst_n)
      (hwr && haddr == H_MODEM && !lwr && !hrd) |=> $stable(modem_q));
endmodule

// File: tb/sim_uart_mimic_bridge.sv
module sim_uart_mimic_bridge;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] haddr = '0;
   logic [7:0] hwdata = '0, lwdata = '0, laddr = '0;
   logic       hwr = 0, hrd = 0, lwr = 0, lrd = 0;
   logic [7:0] hrdata, lrdata;
   logic       lirq;
   int checks = 0, errors = 0;
   bit done = 0;

   logic [7:0] hq_exp[$], lq_exp[$];
   string      hq_tag[$], lq_tag[$];

   always #4 clk = ~clk;

   uart_mimic_bridge u0 (.clk, .rst_n, .haddr, .hwdata, .hwr, .hrd, .hrdata,
                         .laddr, .lwdata, .lwr, .lrd, .lrdata, .lirq);

   task automatic judge(string tag, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %02h expected %02h", tag, act, exp);
      end
   endtask

   // monitor: pop expectations as reads appear
   always @(negedge clk) begin
      #2;
      if (hrd && hq_exp.size() > 0) judge(hq_tag.pop_front(), hrdata, hq_exp.pop_front());
      if (lrd && lq_exp.size() > 0) judge(lq_tag.pop_front(), lrdata, lq_exp.pop_front());
   end

   task automatic idle();
      @(negedge clk); hwr = 0; hrd = 0; lwr = 0; lrd = 0;
   endtask
   task automatic h_wr(logic [2:0] a, logic [7:0] d);
      @(negedge clk); haddr = a; hwdata = d; hwr = 1;
      idle();
   endtask
   task automatic h_rd(logic [2:0] a, logic [7:0] e, string t);
      @(negedge clk); haddr = a; hrd = 1; hq_exp.push_back(e); hq_tag.push_back(t);
      idle();
   endtask
   task automatic l_wr(logic [7:0] a, logic [7:0] d);
      @(negedge clk); laddr = a; lwdata = d; lwr = 1;
      idle();
   endtask
   task automatic l_rd(logic [7:0] a, logic [7:0] e, string t);
      @(negedge clk); laddr = a; lrd = 1; lq_exp.push_back(e); lq_tag.push_back(t);
      idle();
   endtask
   task automatic irq_is(logic e, string t);
      @(negedge clk); #2; judge(t, {7'd0, lirq}, {7'd0, e});
   endtask

   initial begin
      #(8*200000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual hung expected done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset values
      h_rd(3'd0, 8'h00, "R1 div lo"); h_rd(3'd1, 8'h00, "R1 div hi");
      h_rd(3'd3, 8'h00, "R1 line");   h_rd(3'd6, 8'h00, "R1 modem");
      h_rd(3'd7, 8'h00, "R1 scratch");
      l_rd(8'hF7, 8'h00, "R1 local scr"); l_rd(8'hF8, 8'h00, "R1 local lo");
      l_rd(8'hF9, 8'h00, "R1 local hi");  irq_is(1'b0, "R1 irq");
      // R7 scratch
      h_wr(3'd7, 8'hA5); irq_is(1'b0, "R7 no irq");
      h_rd(3'd7, 8'hA5, "R7 host rb"); l_rd(8'hF7, 8'hA5, "R7 local rb");
      // R8 gating with access bit clear
      h_wr(3'd0, 8'h33); irq_is(1'b0, "R8 gated no irq");
      h_rd(3'd0, 8'h00, "R8 gated read");
      h_wr(3'd3, 8'h80); h_rd(3'd3, 8'h80, "R8 line rb");
      h_rd(3'd0, 8'h00, "R8 divisor untouched");
      l_rd(8'hF8, 8'h00, "R8 local untouched");
      // R9 interrupt
      h_wr(3'd0, 8'h12); irq_is(1'b1, "R9 set lo");
      l_rd(8'hF9, 8'h00, "R9 hi still 0"); irq_is(1'b0, "R9 ack by hi");
      h_wr(3'd1, 8'h34); irq_is(1'b1, "R9 set hi");
      h_rd(3'd1, 8'h34, "R8 host hi rb"); irq_is(1'b1, "R9 host read keeps");
      l_rd(8'hF8, 8'h12, "R8 local lo"); irq_is(1'b0, "R9 ack by lo");
      l_rd(8'hF9, 8'h34, "R8 local hi");
      // R10 set and ack together
      @(negedge clk); haddr = 3'd0; hwdata = 8'h56; hwr = 1; laddr = 8'hF8; lrd = 1;
      lq_exp.push_back(8'h12); lq_tag.push_back("R10 old byte");
      idle(); irq_is(1'b1, "R10 set wins");
      l_rd(8'hF8, 8'h56, "R10 new byte"); irq_is(1'b0, "R10 acked");
      // R8 access bit off again
      h_wr(3'd3, 8'h03); h_rd(3'd0, 8'h00, "R8 hidden again");
      h_rd(3'd3, 8'h03, "R8 line low bits"); l_rd(8'hF8, 8'h56, "R8 local keeps");
      // R11 unmapped / local writes elsewhere
      l_rd(8'hF5, 8'h00, "R11 unmapped");
      l_wr(8'hF7, 8'hFF); l_rd(8'hF7, 8'hA5, "R11 local write ignored");
      // R3 R4 modem deltas
      l_wr(8'hF6, 8'hF0);
      h_rd(3'd6, 8'hFB, "R3 R4 deltas on rise");
      h_rd(3'd6, 8'hF0, "R5 cleared");
      l_wr(8'hF6, 8'hB0);
      h_rd(3'd6, 8'hB4, "R4 ring fall");
      h_rd(3'd6, 8'hB0, "R5 cleared again");
      l_wr(8'hF6, 8'hB0);
      h_rd(3'd6, 8'hB0, "R3 no change no delta");
      l_rd(8'hF6, 8'hB0, "R2 local view");
      // R2 host cannot write
      h_wr(3'd6, 8'h0F); h_rd(3'd6, 8'hB0, "R2 host write ignored");
      // R6 read and transition together
      @(negedge clk); haddr = 3'd6; hrd = 1; laddr = 8'hF6; lwdata = 8'hA0; lwr = 1;
      hq_exp.push_back(8'hB0); hq_tag.push_back("R6 read old");
      idle();
      h_rd(3'd6, 8'hA1, "R6 delta survives");
      h_rd(3'd6, 8'hA0, "R6 then clears");
      repeat (2) @(negedge clk);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule